// File: doc/BRIEF.md
# Multi-Cycle Shift and Rotate Unit

This unit shifts or rotates an 8-bit or 16-bit operand by a count of up to 31 positions. It performs one single-bit step on each clock, so a count of N takes N cycles. The datapath handles four families: plain rotates, rotates that pass through the carry flag, logical shifts and arithmetic shifts. A rotate through carry moves the carry bit around as a ninth bit in byte mode and as a seventeenth bit in word mode.

A caller presents the operand, the width select, the operation code, the count and the current flag values, and pulses `start` for one cycle. The unit holds `busy` while it steps. It then raises `done` for one cycle, and in that cycle `result` and the flag outputs carry the final values. The outputs keep those values until the next accepted start. The count may come from an immediate field or from a count register, and the unit does not distinguish the two.

Top module: `shift_rotate_unit`

## Requirements
- R1: After a start with count N in 1..31 is accepted at a clock edge, `done` is high after the Nth following edge, and `busy` is high from the accepting edge up to that point. `busy` is low while `done` is high.
- R2: Plain rotates use codes ROL=0 and ROR=1. A byte ROL by 1 of 1Ch gives 38h with carry 0, and a byte ROR by 1 of 1Ch gives 0Eh with carry 0. In a plain rotate the carry takes the bit that wrapped around.
- R3: Rotates through carry use codes RCL=2 and RCR=3. With carry in 1, a byte RCL by 1 of 1Ch gives 39h with carry 0, and a byte RCR by 1 gives 8Eh with carry 0. A rotate by 9 in byte mode, or by 17 in word mode, returns both the operand and the carry unchanged.
- R4: Shifts use codes SHL=4, SHR=5, SAL=6 (the same as SHL) and SAR=7. A byte SHL or SAL by 1 of E0h gives C0h with carry 1. A byte SAR by 1 gives F0h from E0h and 26h from 4Ch, both with carry 0. A byte SHR by 1 of 07h gives 03h with carry 1. The carry takes the last bit shifted out.
- R5: The result and carry of any operation with count N equal the single-bit operation applied N times.
- R6: When `wide`=0 the unit ignores `operand[15:8]`, works on bit 7 as the sign bit, and drives `result[15:8]` to zero.
- R7: A count of 0 finishes with `done` after the accepting edge. The result is then the operand limited to the selected width, and every flag output equals its input.
- R8: For a count of 1, OF becomes the new sign bit XOR the new carry for the left operations (0, 2, 4, 6). For ROR and RCR it becomes the XOR of the two top result bits. For SHR it becomes the original sign bit, and for SAR it becomes 0. For a count above 1, OF keeps `of_in`.
- R9: For shifts (codes 4 to 7) with a nonzero count, SF is the result sign bit, ZF is 1 when the width-limited result is zero, and PF is 1 when `result[7:0]` has an even number of ones. Rotates pass SF, ZF and PF through unchanged.
- R10: A `start` that arrives while `busy` is high has no effect on the operation in progress, its result or its latency.
- R11: `done` is high for exactly one cycle per accepted start. After reset, `result`, all flag outputs, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| op | input | 3 | Operation code (see R2 to R4) |
| wide | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| count | input | CNT_W | Number of single-bit steps |
| operand | input | 16 | Value to shift or rotate |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| sf_in | input | 1 | Incoming sign flag |
| zf_in | input | 1 | Incoming zero flag |
| pf_in | input | 1 | Incoming parity flag |
| result | output | 16 | Shifted or rotated value, final when done |
| cf_out | output | 1 | Carry flag |
| of_out | output | 1 | Overflow flag |
| sf_out | output | 1 | Sign flag |
| zf_out | output | 1 | Zero flag |
| pf_out | output | 1 | Parity flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the operand, the width, the code, the count and the flag inputs are sampled only on the edge that accepts `start`. That is why each property refers to latched state or to the accepting cycle, and never to the live inputs during a run. The bench changes those inputs only at falling edges, holds `start` for a single cycle, and keeps the count within the CNT_W range. When it tests that a `start` arriving mid-run has no effect, it deliberately drives a different operand and count at the same moment.

// File: rtl/sru_pkg.sv
package sru_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    OP_ROL = 3'd0,
    OP_ROR = 3'd1,
    OP_RCL = 3'd2,
    OP_RCR = 3'd3,
    OP_SHL = 3'd4,
    OP_SHR = 3'd5,
    OP_SAL = 3'd6,
    OP_SAR = 3'd7
  } sr_op_e;

  typedef struct packed {
    logic  cf;
    word_t val;
  } step_t;

  function automatic word_t width_mask(logic wide);
    return wide ? '1 : word_t'({BYTE_W{1'b1}});
  endfunction

  function automatic logic sign_of(word_t v, logic wide);
    return wide ? v[WORD_W-1] : v[BYTE_W-1];
  endfunction

  function automatic logic below_sign(word_t v, logic wide);
    return wide ? v[WORD_W-2] : v[BYTE_W-2];
  endfunction

  function automatic word_t sign_place(logic wide);
    return wide ? (word_t'(1) << (WORD_W-1)) : (word_t'(1) << (BYTE_W-1));
  endfunction

  function automatic logic is_shift(sr_op_e op);
    return op[2];
  endfunction

  function automatic logic shifts_left(sr_op_e op);
    return ~op[0];
  endfunction

  // One single-bit step; v is assumed already limited to the width.
  function automatic step_t one_step(word_t v, logic c, sr_op_e op, logic wide);
    step_t r;
    word_t m;
    logic  top;
    m   = width_mask(wide);
    top = sign_of(v, wide);
    unique case (op)
      OP_ROL: begin r.val = ((v << 1) | word_t'(top)) & m; r.cf = top;  end
      OP_ROR: begin r.val = (v >> 1) | (v[0] ? sign_place(wide) : '0); r.cf = v[0]; end
      OP_RCL: begin r.val = ((v << 1) | word_t'(c)) & m; r.cf = top;  end
      OP_RCR: begin r.val = (v >> 1) | (c ? sign_place(wide) : '0); r.cf = v[0]; end
      OP_SHL,
      OP_SAL: begin r.val = (v << 1) & m; r.cf = top; end
      OP_SHR: begin r.val = v >> 1; r.cf = v[0]; end
      OP_SAR: begin r.val = (v >> 1) | (top ? sign_place(wide) : '0); r.cf = v[0]; end
      default: begin r.val = v; r.cf = c; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sru_stepper.sv
module sru_stepper
  import sru_pkg::*;
(
  input  word_t  cur_val,
  input  logic   cur_cf,
  input  sr_op_e op,
  input  logic   wide,
  output word_t  nxt_val,
  output logic   nxt_cf
);
  step_t s;

  always_comb begin
    s       = one_step(cur_val, cur_cf, op, wide);
    nxt_val = s.val;
    nxt_cf  = s.cf;
  end
endmodule

// File: rtl/sru_flagcalc.sv
module sru_flagcalc
  import sru_pkg::*;
(
  input  word_t  pre_val,
  input  word_t  post_val,
  input  logic   post_cf,
  input  sr_op_e op,
  input  logic   wide,
  output logic   of_calc,
  output logic   sf_calc,
  output logic   zf_calc,
  output logic   pf_calc
);
  always_comb begin
    if (shifts_left(op))
      of_calc = sign_of(post_val, wide) ^ post_cf;
    else if (op == OP_SHR)
      of_calc = sign_of(pre_val, wide);
    else if (op == OP_SAR)
      of_calc = 1'b0;
    else
      of_calc = sign_of(post_val, wide) ^ below_sign(post_val, wide);

    sf_calc = sign_of(post_val, wide);
    zf_calc = ((post_val & width_mask(wide)) == '0);
    pf_calc = ~^post_val[BYTE_W-1:0];
  end
endmodule

// File: rtl/sru_ctrl.sv
module sru_ctrl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  output logic             accept,
  output logic             busy,
  output logic             last_step,
  output logic             single,
  output logic             done
);
  logic [CNT_W-1:0] rem_q;

  assign accept    = start && !busy;
  assign last_step = busy && (rem_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      rem_q  <= '0;
      single <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        single <= (count == CNT_W'(1));
        if (count == '0) begin
          done <= 1'b1;
        end else begin
          busy  <= 1'b1;
          rem_q <= count;
        end
      end else if (last_step) begin
        busy  <= 1'b0;
        rem_q <= '0;
        done  <= 1'b1;
      end else if (busy) begin
        rem_q <= rem_q - CNT_W'(1);
      end
    end
  end

  // R11: the completion pulse lasts one cycle
  a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1: the final step is followed by done with busy released
  a_r1_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> (done && !busy));

  // R1: never busy and done together
  a_r1_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10: a running operation keeps counting down whatever start does
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> (busy && rem_q == $past(rem_q) - CNT_W'(1)));
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic             wide,
  input  logic [CNT_W-1:0] count,
  input  logic [15:0]      operand,
  input  logic             cf_in,
  input  logic             of_in,
  input  logic             sf_in,
  input  logic             zf_in,
  input  logic             pf_in,
  output logic [15:0]      result,
  output logic             cf_out,
  output logic             of_out,
  output logic             sf_out,
  output logic             zf_out,
  output logic             pf_out,
  output logic             busy,
  output logic             done
);
  word_t  val_q;
  logic   cf_q, of_q, sf_q, zf_q, pf_q;
  sr_op_e op_q;
  logic   wide_q;

  logic   accept, last_step, single;
  word_t  step_val;
  logic   step_cf;
  logic   of_calc, sf_calc, zf_calc, pf_calc;

  sru_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .count     (count),
    .accept    (accept),
    .busy      (busy),
    .last_step (last_step),
    .single    (single),
    .done      (done)
  );

  sru_stepper u_step (
    .cur_val (val_q),
    .cur_cf  (cf_q),
    .op      (op_q),
    .wide    (wide_q),
    .nxt_val (step_val),
    .nxt_cf  (step_cf)
  );

  sru_flagcalc u_flags (
    .pre_val  (val_q),
    .post_val (step_val),
    .post_cf  (step_cf),
    .op       (op_q),
    .wide     (wide_q),
    .of_calc  (of_calc),
    .sf_calc  (sf_calc),
    .zf_calc  (zf_calc),
    .pf_calc  (pf_calc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      cf_q   <= 1'b0;
      of_q   <= 1'b0;
      sf_q   <= 1'b0;
      zf_q   <= 1'b0;
      pf_q   <= 1'b0;
      op_q   <= OP_ROL;
      wide_q <= 1'b0;
    end else if (accept) begin
      val_q  <= operand & width_mask(wide);
      cf_q   <= cf_in;
      of_q   <= of_in;
      sf_q   <= sf_in;
      zf_q   <= zf_in;
      pf_q   <= pf_in;
      op_q   <= sr_op_e'(op);
      wide_q <= wide;
    end else if (busy) begin
      val_q <= step_val;
      cf_q  <= step_cf;
      if (last_step) begin
        if (single) of_q <= of_calc;
        if (is_shift(op_q)) begin
          sf_q <= sf_calc;
          zf_q <= zf_calc;
          pf_q <= pf_calc;
        end
      end
    end
  end

  assign result = val_q;
  assign cf_out = cf_q;
  assign of_out = of_q;
  assign sf_out = sf_q;
  assign zf_out = zf_q;
  assign pf_out = pf_q;

  // R6: byte mode never exposes a high byte
  a_r6_high_byte_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy || done) && !wide_q) |-> (result[15:8] == 8'h00));

  // R9: rotates never touch sign, zero or parity
  a_r9_rotate_keeps_szp: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_shift(op_q)) |=> $stable({sf_out, zf_out, pf_out}));

  // R8: multi-step runs keep the overflow flag
  a_r8_of_held_multistep: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !single) |=> $stable(of_out));

  // R7: a zero count completes at once with the operand and flags passed through
  a_r7_zero_count_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && count == '0) |=> (done && result == $past(operand & width_mask(wide))
      && cf_out == $past(cf_in) && of_out == $past(of_in)));
endmodule

// File: tb/test_shift_rotate_unit.sv
module test_shift_rotate_unit;
  localparam int PERIOD = 10;
  localparam int CW = 5;
  localparam int NVEC = 14;

  // {op[3], wide, count[5], cf_in, operand[16], expected result[16], expected cf}
  localparam logic [42:0] VECS [NVEC] = '{
    {3'd0, 1'b0, 5'd1,  1'b0, 16'h001C, 16'h0038, 1'b0},  // R2 ROL
    {3'd1, 1'b0, 5'd1,  1'b0, 16'h001C, 16'h000E, 1'b0},  // R2 ROR
    {3'd2, 1'b0, 5'd1,  1'b1, 16'h001C, 16'h0039, 1'b0},  // R3 RCL
    {3'd3, 1'b0, 5'd1,  1'b1, 16'h001C, 16'h008E, 1'b0},  // R3 RCR
    {3'd4, 1'b0, 5'd1,  1'b0, 16'h00E0, 16'h00C0, 1'b1},  // R4 SHL
    {3'd6, 1'b0, 5'd1,  1'b0, 16'h00E0, 16'h00C0, 1'b1},  // R4 SAL
    {3'd7, 1'b0, 5'd1,  1'b0, 16'h00E0, 16'h00F0, 1'b0},  // R4 SAR neg
    {3'd7, 1'b0, 5'd1,  1'b0, 16'h004C, 16'h0026, 1'b0},  // R4 SAR pos
    {3'd5, 1'b0, 5'd1,  1'b0, 16'h0007, 16'h0003, 1'b1},  // R4 SHR
    {3'd2, 1'b0, 5'd9,  1'b0, 16'h00A5, 16'h00A5, 1'b0},  // R3 9-bit ring
    {3'd2, 1'b1, 5'd17, 1'b1, 16'h1234, 16'h1234, 1'b1},  // R3 17-bit ring
    {3'd0, 1'b1, 5'd4,  1'b0, 16'h1234, 16'h2341, 1'b1},  // R5 ROL word
    {3'd5, 1'b1, 5'd16, 1'b0, 16'hFFFF, 16'h0000, 1'b1},  // R5 SHR word
    {3'd7, 1'b1, 5'd3,  1'b0, 16'h8000, 16'hF000, 1'b0}   // R5 SAR word
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op = '0;
  logic wide = 1'b0;
  logic [CW-1:0] count = '0;
  logic [15:0] operand = '0;
  logic cf_in = 0, of_in = 0, sf_in = 0, zf_in = 0, pf_in = 0;
  logic [15:0] result;
  logic cf_out, of_out, sf_out, zf_out, pf_out, busy, done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  shift_rotate_unit #(.CNT_W(CW)) i_shift_rotate_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide), .count(count),
    .operand(operand), .cf_in(cf_in), .of_in(of_in), .sf_in(sf_in), .zf_in(zf_in),
    .pf_in(pf_in), .result(result), .cf_out(cf_out), .of_out(of_out), .sf_out(sf_out),
    .zf_out(zf_out), .pf_out(pf_out), .busy(busy), .done(done)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: treats the value plus carry as plain integers.
  function automatic void model(input int o, input int w, input int n, input int ci,
                                input int v, input int oi, input int si, input int zi,
                                input int pi, output int r, output int c, output int of,
                                output int s, output int z, output int p);
    int bits, msk, hi, orig_hi;
    bits = w ? 16 : 8;
    msk = (1 << bits) - 1;
    r = v & msk; c = ci; of = oi; s = si; z = zi; p = pi;
    orig_hi = (r >> (bits - 1)) & 1;
    for (int k = 0; k < n; k++) begin
      hi = (r >> (bits - 1)) & 1;
      case (o)
        0: begin c = hi; r = ((r << 1) | hi) & msk; end
        1: begin c = r & 1; r = (r >> 1) | ((r & 1) << (bits - 1)); end
        2: begin r = ((r << 1) | c) & msk; c = hi; end
        3: begin hi = r & 1; r = (r >> 1) | (c << (bits - 1)); c = hi; end
        4, 6: begin c = hi; r = (r << 1) & msk; end
        5: begin c = r & 1; r = r >> 1; end
        default: begin c = r & 1; r = (r >> 1) | (hi << (bits - 1)); end
      endcase
    end
    if (n == 1) begin
      hi = (r >> (bits - 1)) & 1;
      case (o)
        0, 2, 4, 6: of = hi ^ c;
        1, 3: of = hi ^ ((r >> (bits - 2)) & 1);
        5: of = orig_hi;
        default: of = 0;
      endcase
    end
    if (n > 0 && o >= 4) begin
      s = (r >> (bits - 1)) & 1;
      z = (r == 0) ? 1 : 0;
      p = ($countones(r & 8'hFF) % 2 == 0) ? 1 : 0;
    end
  endfunction

  task automatic do_op(string tag, int o, int w, int n, int ci, int v,
                       int oi, int si, int zi, int pi, bit poke);
    int er, ec, eo, es, ez, ep, k;
    model(o, w, n, ci, v, oi, si, zi, pi, er, ec, eo, es, ez, ep);
    @(negedge clk);
    op = 3'(o); wide = w[0]; count = CW'(n); cf_in = ci[0]; operand = 16'(v);
    of_in = oi[0]; sf_in = si[0]; zf_in = zi[0]; pf_in = pi[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 40) begin
      if (poke && k == 0) begin
        operand = ~operand; count = CW'(2); op = 3'(o ^ 1); cf_in = ~cf_in;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    chk({tag, " latency (R1)"}, k, n);
    chk({tag, " result"}, int'(result), er);
    chk({tag, " carry"}, int'(cf_out), ec);
    chk({tag, " overflow (R8)"}, int'(of_out), eo);
    chk({tag, " sign (R9)"}, int'(sf_out), es);
    chk({tag, " zero (R9)"}, int'(zf_out), ez);
    chk({tag, " parity (R9)"}, int'(pf_out), ep);
    @(negedge clk);
    chk({tag, " done drops (R11)"}, int'(done), 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset result", int'(result), 0);
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset busy", int'(busy), 0);
    chk("R11 reset carry", int'(cf_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [42:0] vv;
      vv = VECS[i];
      do_op("table", int'(vv[42:40]), int'(vv[39]), int'(vv[38:34]), int'(vv[33]),
            int'(vv[32:17]), 0, 0, 0, 0, 1'b0);
      chk("R2 R3 R4 table result", int'(result), int'(vv[16:1]));
      chk("R2 R3 R4 table carry", int'(cf_out), int'(vv[0]));
    end

    // R7 zero count, byte and word
    do_op("R7 zero byte", 4, 0, 0, 1, 16'hBEEF, 1, 0, 1, 0, 1'b0);
    chk("R7 zero byte value", int'(result), 16'h00EF);
    do_op("R7 zero word", 7, 1, 0, 0, 16'h8001, 0, 1, 0, 1, 1'b0);

    // R6 high byte ignored: same low byte, different high byte
    do_op("R6 high ignored A", 1, 0, 3, 0, 16'h0096, 0, 0, 0, 0, 1'b0);
    do_op("R6 high ignored B", 1, 0, 3, 0, 16'hFF96, 0, 0, 0, 0, 1'b0);
    chk("R6 high byte zero", int'(result[15:8]), 0);

    // R8 OF held for count 2, computed for count 1
    do_op("R8 of held", 4, 0, 2, 0, 16'h0040, 1, 0, 0, 0, 1'b0);
    do_op("R8 of shr", 5, 1, 1, 0, 16'h8000, 0, 0, 0, 0, 1'b0);
    do_op("R8 of sar", 7, 1, 1, 0, 16'h8000, 1, 0, 0, 0, 1'b0);

    // R9 rotate passes SF/ZF/PF; shift to zero sets ZF
    do_op("R9 rotate keeps", 3, 1, 5, 1, 16'h0F0F, 0, 1, 1, 1, 1'b0);
    do_op("R9 shift to zero", 5, 0, 8, 0, 16'h00FF, 0, 1, 0, 0, 1'b0);

    // R10 start while busy is ignored
    do_op("R10 busy start", 0, 1, 6, 0, 16'hA55A, 0, 0, 0, 0, 1'b1);
    do_op("R10 busy start rcr", 3, 0, 12, 1, 16'h0081, 0, 0, 0, 0, 1'b1);

    // R5 pseudo-random sweep
    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      int o, w, n;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      o = int'(lfsr[2:0]);
      w = int'(lfsr[3]);
      n = int'(lfsr[8:4]) % 20;
      do_op("R5 sweep", o, w, n, int'(lfsr[9]), int'({lfsr[7:0], lfsr[15:8]}),
            int'(lfsr[10]), int'(lfsr[11]), int'(lfsr[12]), int'(lfsr[13]), 1'b0);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule